// File: doc/BRIEF.md
# Packet Container Packer

This block gathers variable-length Ethernet packets into one fixed-size container of 1024 words of 32 bits (4 KB). Packet bytes arrive one per cycle, each with a valid qualifier. A start marker opens a packet and an end marker closes it. Each packet starts on a fresh word and goes into the container's data area, which begins after a 34-word header. The packet's last word is padded with zero bytes. Each packet's byte length is held in the block.

A producer sends packets until it asks for the container to be closed. The block then writes the whole header into the container memory. Header word 0 carries the useful word count and the packet count. Header words 1 to 33 each carry two 16-bit packet lengths. When the header is written, the block raises a full flag. The consumer reads the container through a simple synchronous read port, then issues a release. The release empties the container for the next batch.

A packet that does not fit in the remaining data space is refused and reported with a one-cycle drop pulse. A packet beyond the 66-packet limit is also refused, as is a packet arriving while the container is closing or full. A refused packet leaves the container as it was.

Top module: `cpk_container_packer`

## Requirements
- R1: After reset `full` and `drop` are low and the container is empty: closing it at once yields header word 0 equal to 0x0022_0000 (34 useful words, 0 packets).
- R2: Byte k of an accepted packet is stored in data word P + k/4, in bits [8*(k%4)+7 : 8*(k%4)]. P is the first word after the previous accepted packet, and is 34 for the first packet. Unused bytes of the last word read as zero.
- R3: Header word 0 holds the useful word count in bits [31:16] and the packet count in bits [15:0]. The useful word count is 34 plus all padded data words.
- R4: Header word 1 + i/2 holds the byte length of packet i: in bits [31:16] when i is even and in bits [15:0] when i is odd. Length slots with no packet read as zero.
- R5: A packet whose padded word count exceeds the remaining data space is refused. `drop` pulses for one cycle, in the cycle after its end marker is sampled. Counts and the write position stay unchanged, so the next packet takes its place.
- R6: At most 66 packets are accepted into one container. Any further packet is refused with a `drop` pulse.
- R7: A close request sampled while the container is open makes `full` rise exactly 34 clock edges later. During those edges the 34 header words are written.
- R8: A packet whose start marker is sampled while `full` is high is refused with a `drop` pulse. Header and data words keep their values.
- R9: A release sampled while `full` is high clears `full` at that edge. It also clears the packet count, the lengths and the write position.
- R10: `rd_data` shows the container word at the `rd_addr` sampled on the previous clock edge.
- R11: A packet in progress when a close request is sampled is refused with a `drop` pulse after its end marker, and is not counted in the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A packet byte is present this cycle |
| in_sop | input | 1 | The byte is the first of a packet |
| in_eop | input | 1 | The byte is the last of a packet |
| in_byte | input | 8 | Packet byte |
| close_req | input | 1 | Close the container and write its header |
| release_req | input | 1 | Consumer has finished; empty the container |
| rd_addr | input | 10 | Container word address to read |
| rd_data | output | 32 | Container word, one cycle after its address |
| full | output | 1 | Header written; container ready for the consumer |
| drop | output | 1 | One-cycle pulse: the packet just ended was refused |

## Verification
The assertions assume the byte stream is well formed. Every packet begins with a start marker. No start marker appears inside a packet. Close and release are one-cycle pulses. The bench drives only whole packets, with random idle gaps between bytes. It issues the close request either between packets or, in the single in-flight case, at a byte inside a packet that it then finishes normally. It raises release only while `full` is high.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

    parameter int unsigned CPK_WORDS     = 1024;
    parameter int unsigned CPK_HDR_WORDS = 34;
    parameter int unsigned CPK_MAX_PKTS  = 66;

    typedef enum logic [1:0] {
        CT_OPEN = 2'd0,
        CT_HDR  = 2'd1,
        CT_FULL = 2'd2
    } ctr_state_e;

    // Result of a packet that ended without refusal
    typedef struct packed {
        logic        valid;
        logic [15:0] len;
        logic [15:0] end_ptr;
    } commit_t;

    function automatic logic [31:0] pack_summary(input logic [15:0] words,
                                                 input logic [15:0] pkts);
        return {words, pkts};
    endfunction

    function automatic logic [31:0] pack_pair(input logic [15:0] even_len,
                                              input logic [15:0] odd_len);
        return {even_len, odd_len};
    endfunction

    function automatic logic [31:0] lane_insert(input logic [31:0] acc,
                                                input logic [1:0]  lane,
                                                input logic [7:0]  b);
        logic [31:0] r;
        r = acc;
        r[8*lane +: 8] = b;
        return r;
    endfunction

endpackage

// File: rtl/cpk_ram.sv
module cpk_ram #(
    parameter int unsigned WORDS = cpk_pkg::CPK_WORDS,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/cpk_assembler.sv
module cpk_assembler
    import cpk_pkg::*;
#(
    parameter int unsigned WORDS = CPK_WORDS,
    parameter int unsigned HDR   = CPK_HDR_WORDS,
    localparam int unsigned AW   = $clog2(WORDS),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [7:0]    in_byte,
    input  logic          open,
    input  logic          cap_hit,
    input  logic [PW-1:0] base_ptr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output commit_t       commit,
    output logic          drop
);
    logic          busy_q, bad_q;
    logic [PW-1:0] ptr_q;
    logic [31:0]   acc_q;
    logic [1:0]    lane_q;
    logic [15:0]   cnt_q;

    logic          take, word_done, room;
    logic          s_bad, n_bad;
    logic [PW-1:0] s_ptr, n_ptr;
    logic [31:0]   s_acc, n_acc;
    logic [1:0]    s_lane;
    logic [15:0]   s_cnt, n_cnt;
    logic          drop_d;

    always_comb begin
        take   = in_valid && (in_sop || busy_q);
        s_bad  = bad_q;
        s_ptr  = ptr_q;
        s_acc  = acc_q;
        s_lane = lane_q;
        s_cnt  = cnt_q;
        if (in_sop) begin
            s_bad  = cap_hit;
            s_ptr  = base_ptr;
            s_acc  = '0;
            s_lane = '0;
            s_cnt  = '0;
        end
        n_acc     = lane_insert(s_acc, s_lane, in_byte);
        n_cnt     = s_cnt + 16'd1;
        word_done = take && ((s_lane == 2'd3) || in_eop);
        room      = s_ptr < PW'(WORDS);
        n_bad     = s_bad || !open || (word_done && !room);
        n_ptr     = word_done ? s_ptr + PW'(1) : s_ptr;

        wr_en   = word_done && !n_bad;
        wr_addr = s_ptr[AW-1:0];
        wr_data = n_acc;

        commit.valid   = take && in_eop && !n_bad;
        commit.len     = n_cnt;
        commit.end_ptr = 16'(n_ptr);
        drop_d         = take && in_eop && n_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            bad_q  <= 1'b0;
            ptr_q  <= PW'(HDR);
            acc_q  <= '0;
            lane_q <= '0;
            cnt_q  <= '0;
            drop   <= 1'b0;
        end else begin
            drop <= drop_d;
            if (take) begin
                busy_q <= !in_eop;
                bad_q  <= n_bad;
                ptr_q  <= n_ptr;
                acc_q  <= word_done ? 32'd0 : n_acc;
                lane_q <= word_done ? 2'd0 : s_lane + 2'd1;
                cnt_q  <= n_cnt;
            end
        end
    end

    // R2
    wr_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(wr_addr) >= HDR));

    // R5
    drop_origin_chk: assert property (@(posedge clk) disable iff (rst)
        drop |-> $past(in_valid && in_eop));

endmodule

// File: rtl/cpk_header_seq.sv
module cpk_header_seq
    import cpk_pkg::*;
#(
    parameter int unsigned WORDS = CPK_WORDS,
    parameter int unsigned HDR   = CPK_HDR_WORDS,
    parameter int unsigned MAX   = CPK_MAX_PKTS,
    localparam int unsigned AW   = $clog2(WORDS),
    localparam int unsigned PW   = AW + 1,
    localparam int unsigned CW   = $clog2(MAX + 2),
    localparam int unsigned IW   = $clog2(HDR)
) (
    input  logic          clk,
    input  logic          rst,
    input  commit_t       commit,
    input  logic          close_req,
    input  logic          release_req,
    output logic          open,
    output logic          cap_hit,
    output logic [PW-1:0] base_ptr,
    output logic          hdr_we,
    output logic [AW-1:0] hdr_addr,
    output logic [31:0]   hdr_data,
    output logic          full
);
    ctr_state_e    state;
    logic [CW-1:0] count;
    logic [PW-1:0] dptr;
    logic [IW-1:0] idx;
    logic [15:0]   lens [MAX];
    logic [CW-1:0] sel_e;
    logic          clear;

    assign open     = (state == CT_OPEN);
    assign full     = (state == CT_FULL);
    assign cap_hit  = (count == CW'(MAX));
    assign base_ptr = dptr;
    assign hdr_we   = (state == CT_HDR);
    assign hdr_addr = AW'(idx);
    assign clear    = full && release_req;

    always_comb begin
        sel_e = CW'((32'(idx) - 32'd1) * 32'd2);
        if (idx == '0) begin
            hdr_data = pack_summary(16'(dptr), 16'(count));
        end else begin
            hdr_data = pack_pair(lens[sel_e], lens[sel_e + CW'(1)]);
        end
    end

    genvar g;
    generate
        for (g = 0; g < MAX; g++) begin : g_len
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    lens[g] <= '0;
                end else if (open && commit.valid && (count == CW'(g))) begin
                    lens[g] <= commit.len;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CT_OPEN;
            count <= '0;
            dptr  <= PW'(HDR);
            idx   <= '0;
        end else begin
            case (state)
                CT_OPEN: begin
                    if (commit.valid) begin
                        count <= count + CW'(1);
                        dptr  <= PW'(commit.end_ptr);
                    end
                    if (close_req) begin
                        state <= CT_HDR;
                        idx   <= '0;
                    end
                end
                CT_HDR: begin
                    idx <= idx + IW'(1);
                    if (idx == IW'(HDR - 1)) begin
                        state <= CT_FULL;
                    end
                end
                CT_FULL: begin
                    if (release_req) begin
                        state <= CT_OPEN;
                        count <= '0;
                        dptr  <= PW'(HDR);
                    end
                end
                default: state <= CT_OPEN;
            endcase
        end
    end

    // R6
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        32'(count) <= MAX);

    // R5
    dptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(dptr) >= HDR) && (32'(dptr) <= WORDS));

    // R7
    full_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(hdr_we && (32'(hdr_addr) == HDR - 1)));

    // R9
    release_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (full && release_req) |=> (!full && (count == '0) && (32'(dptr) == HDR)));

endmodule

// File: rtl/cpk_container_packer.sv
module cpk_container_packer
    import cpk_pkg::*;
#(
    parameter int unsigned WORDS = CPK_WORDS,
    parameter int unsigned HDR   = CPK_HDR_WORDS,
    parameter int unsigned MAX   = CPK_MAX_PKTS,
    localparam int unsigned AW   = $clog2(WORDS),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [7:0]    in_byte,
    input  logic          close_req,
    input  logic          release_req,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          full,
    output logic          drop
);
    logic          open, cap_hit;
    logic [PW-1:0] base_ptr;
    logic          d_we, h_we, m_we;
    logic [AW-1:0] d_addr, h_addr, m_addr;
    logic [31:0]   d_data, h_data, m_data;
    commit_t       commit;

    cpk_assembler #(.WORDS(WORDS), .HDR(HDR)) u_asm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_byte  (in_byte),
        .open     (open),
        .cap_hit  (cap_hit),
        .base_ptr (base_ptr),
        .wr_en    (d_we),
        .wr_addr  (d_addr),
        .wr_data  (d_data),
        .commit   (commit),
        .drop     (drop)
    );

    cpk_header_seq #(.WORDS(WORDS), .HDR(HDR), .MAX(MAX)) u_hdr (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .close_req   (close_req),
        .release_req (release_req),
        .open        (open),
        .cap_hit     (cap_hit),
        .base_ptr    (base_ptr),
        .hdr_we      (h_we),
        .hdr_addr    (h_addr),
        .hdr_data    (h_data),
        .full        (full)
    );

    always_comb begin
        m_we   = d_we || h_we;
        m_addr = h_we ? h_addr : d_addr;
        m_data = h_we ? h_data : d_data;
    end

    cpk_ram #(.WORDS(WORDS)) u_ram (
        .clk   (clk),
        .we    (m_we),
        .waddr (m_addr),
        .wdata (m_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R8
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(d_we && h_we));

    // R8
    no_write_full_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !m_we);

endmodule

// File: tb/cpk_container_packer_bench.sv
`timescale 1ns/1ps
module cpk_container_packer_bench;

    localparam int WORDS = 1024;
    localparam int HDR   = 34;
    localparam int MAX   = 66;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sop, in_eop;
    logic [7:0]  in_byte;
    logic        close_req, release_req;
    logic [9:0]  rd_addr;
    logic [31:0] rd_data;
    logic        full, drop;

    int vectors  = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] exp_mem [WORDS];
    logic [15:0] m_lens  [MAX];
    int          m_count;
    int          m_dptr;
    bit          m_open;

    always #2 clk = ~clk;

    cpk_container_packer u_cpk_container_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .close_req(close_req),
        .release_req(release_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .full(full), .drop(drop)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_hdr(input int w);
        if (w == 0) return {16'(m_dptr), 16'(m_count)};
        return {m_lens[2*(w-1)], m_lens[2*(w-1)+1]};
    endfunction

    function automatic bit exp_refuse(input int len);
        int words = (len + 3) / 4;
        return !m_open || (m_count == MAX) || (m_dptr + words > WORDS);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < MAX; i++) m_lens[i] = '0;
        m_count = 0;
        m_dptr  = HDR;
        m_open  = 1'b1;
    endtask

    task automatic read_word(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = 10'(a);
        @(posedge clk);
        @(negedge clk);
        d = rd_data;
    endtask

    // Drive a packet; optionally pulse close at byte index close_at (-1 none)
    task automatic send_pkt(input int len, input int close_at, input string req);
        bit refuse;
        logic [7:0] b;
        refuse = exp_refuse(len) || (close_at >= 0);
        if (!refuse) begin
            for (int w = 0; w < (len + 3) / 4; w++) exp_mem[m_dptr + w] = '0;
        end
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            close_req = 1'b0;
            if (($urandom % 5) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            b = 8'($urandom);
            in_valid = 1'b1;
            in_sop   = (k == 0);
            in_eop   = (k == len - 1);
            in_byte  = b;
            close_req = (k == close_at);
            if (!refuse) exp_mem[m_dptr + k/4][8*(k%4) +: 8] = b;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; close_req = 1'b0;
        check(drop == refuse, req, 32'(drop), 32'(refuse));
        if (close_at >= 0) m_open = 1'b0;
        if (!refuse) begin
            m_lens[m_count] = 16'(len);
            m_count++;
            m_dptr += (len + 3) / 4;
        end
    endtask

    task automatic wait_full(input bool_unused);
        for (int n = 0; n < 100 && !full; n++) @(negedge clk);
    endtask

    task automatic close_ctr();
        int n;
        @(negedge clk);
        close_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        close_req = 1'b0;
        m_open = 1'b0;
        n = 0;
        while (!full && n < 100) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check(n == HDR, "R7 close-to-full edges", 32'(n), 32'(HDR));
    endtask

    task automatic verify_ctr();
        logic [31:0] d;
        read_word(0, d);
        check(d === exp_hdr(0), "R3 summary word (R10 read)", d, exp_hdr(0));
        for (int w = 1; w < HDR; w++) begin
            read_word(w, d);
            check(d === exp_hdr(w), "R4 length word", d, exp_hdr(w));
        end
        for (int a = HDR; a < m_dptr; a++) begin
            read_word(a, d);
            check(d === exp_mem[a], "R2 data word", d, exp_mem[a]);
        end
    endtask

    task automatic release_ctr();
        @(negedge clk);
        release_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        release_req = 1'b0;
        check(full == 1'b0, "R9 full cleared by release", 32'(full), 32'd0);
        model_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, keep;
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_byte = '0;
        close_req = 1'b0; release_req = 1'b0; rd_addr = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(full == 1'b0, "R1 full after reset", 32'(full), 32'd0);
        check(drop == 1'b0, "R1 drop after reset", 32'(drop), 32'd0);

        // R1: empty container closed at once
        close_ctr();
        read_word(0, d);
        check(d === 32'h0022_0000, "R1 empty summary", d, 32'h0022_0000);
        verify_ctr();
        release_ctr();

        // R2 R3 R4: random lengths including corner sizes
        send_pkt(1, -1, "R2 one byte");
        send_pkt(4, -1, "R2 one word");
        send_pkt(5, -1, "R2 word plus one");
        for (int i = 0; i < 17; i++) send_pkt(1 + int'($urandom % 300), -1, "R2 random pkt");
        close_ctr();
        verify_ctr();

        // R8: packet while full is refused, contents kept
        read_word(HDR, keep);
        send_pkt(8, -1, "R8 refused while full");
        read_word(HDR, d);
        check(d === keep, "R8 data kept", d, keep);
        read_word(0, d);
        check(d === exp_hdr(0), "R8 summary kept", d, exp_hdr(0));
        release_ctr();

        // R5: space limit
        for (int i = 0; i < 3; i++) send_pkt(1200, -1, "R5 large fill");
        send_pkt(400, -1, "R5 too big refused");
        send_pkt(357, -1, "R5 exact fit");
        check(m_dptr == WORDS, "R5 model at end", 32'(m_dptr), 32'(WORDS));
        send_pkt(1, -1, "R5 no room refused");
        close_ctr();
        verify_ctr();
        release_ctr();

        // R6: packet count cap
        for (int i = 0; i < MAX; i++) send_pkt(1 + int'($urandom % 60), -1, "R6 fill count");
        send_pkt(4, -1, "R6 beyond cap refused");
        close_ctr();
        verify_ctr();
        release_ctr();

        // R11: close while a packet is in flight
        send_pkt(20, -1, "R11 packet before close");
        send_pkt(24, 5, "R11 in-flight packet refused");
        for (int n = 0; n < 100 && !full; n++) @(negedge clk);
        check(full == 1'b1, "R11 full after close", 32'(full), 32'd1);
        verify_ctr();
        release_ctr();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule